// File: doc/BRIEF.md
# Inter-Core Mailbox Doorbell Unit

This unit gives every processor core a small set of 32-bit doorbell words that other cores use to signal it. Each core owns four doorbells, so a four-core system has sixteen. Software never writes a doorbell's value directly. A write to the doorbell's set address turns on the bits that are 1 in the write data. A write to its clear address turns off the bits that are 1 in the write data. While any bit of a doorbell is on, that doorbell requests an interrupt from the core that owns it. The request stays up as a level until the owner clears the last bit.

Each core has one 8-bit routing register. The register sends each of its four doorbell requests out as a normal interrupt, out as a fast interrupt, or not out at all. The fast-interrupt enable for a doorbell takes priority over its normal enable.

Access is through a simple register bus with several ports. The ports are served in the same cycle, so two agents can hit the same doorbell at once; this collision is resolved in a defined order. The unit drives one normal and one fast request line per doorbell. Combining these lines with other interrupt sources happens outside the unit.

Top module: `mbox_doorbell_unit`

## Requirements
- R1: After reset, every doorbell word, every routing register, both request vectors and all read-data outputs are zero.
- R2: A write to set address 0x080 + 16·c + 4·m sets the bits of doorbell m of core c that are 1 in the write data and leaves the other bits unchanged.
- R3: A write to clear address 0x0C0 + 16·c + 4·m clears the bits of doorbell m of core c that are 1 in the write data and leaves the other bits unchanged.
- R4: A read returns data on its port one cycle after the request. Reading a clear address returns the doorbell's current word. Reading a set address returns zero.
- R5: The routing register of core c is at 0x050 + 4·c. It holds write-data bits [7:0] and reads back with bits [31:8] as zero. Bit m is the normal enable of doorbell m, and bit 4+m is its fast enable.
- R6: Normal request line c·4+m is high exactly when the doorbell is nonzero, its normal enable is set and its fast enable is clear.
- R7: Fast request line c·4+m is high exactly when the doorbell is nonzero and its fast enable is set, whatever its normal enable is. The normal and fast lines of a doorbell are never both high.
- R8: A request stays high while any bit of its doorbell is set, including after partial clears. It falls only when the last bit is cleared.
- R9: When set and clear writes reach the same doorbell in one cycle on different ports, all sets apply first and then all clears. A bit in both masks ends at 0, and a bit only in the set mask ends at 1.
- R10: A write sampled at clock edge k changes the doorbell at edge k and the request lines at edge k+1.
- R11: A write whose address has nonzero bits [1:0], or that falls outside the routing, set and clear windows, changes no doorbell, no routing register and no request line.
- R12: When several ports write the same routing register in one cycle, the highest-numbered port's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | NPORT | Per-port access request |
| bus_write | input | NPORT | Per-port direction, 1 = write |
| bus_addr | input | NPORT*AW | Per-port byte address, port p in slice [p*AW +: AW] |
| bus_wdata | input | NPORT*DW | Per-port write data |
| bus_rdata | output | NPORT*DW | Per-port read data, registered |
| mbx_irq | output | NCORE*MPC | Normal request per doorbell, index c·MPC+m |
| mbx_fiq | output | NCORE*MPC | Fast request per doorbell, index c·MPC+m |

## Verification
The hardest case to reach is a same-cycle collision: a set on one port and a clear on another, aimed at one doorbell, with overlapping and non-overlapping mask bits. The bench reaches it by driving both ports in a single cycle, with a set mask of 0xFF and a clear mask of 0x0F, and reads the word back expecting 0xF0. Two more cases are checked cycle by cycle. One is two ports writing the same routing register in one cycle. The other is the one-cycle gap between a doorbell changing and its request line changing, sampled on the cycle before the line moves and on the cycle it moves.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    parameter int unsigned MBX_PORTS    = 2;
    parameter int unsigned MBX_CORES    = 4;
    parameter int unsigned MBX_PER_CORE = 4;
    parameter int unsigned MBX_DW       = 32;
    parameter int unsigned MBX_AW       = 8;
    parameter int unsigned MBX_CTL_BASE = 'h050;
    parameter int unsigned MBX_SET_BASE = 'h080;
    parameter int unsigned MBX_CLR_BASE = 'h0C0;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_CTL  = 2'd3
    } mbx_op_e;
endpackage

// File: rtl/mbox_addr_decode.sv
module mbox_addr_decode
    import mbox_pkg::*;
#(
    parameter int unsigned AW       = MBX_AW,
    parameter int unsigned NCORE    = MBX_CORES,
    parameter int unsigned MPC      = MBX_PER_CORE,
    parameter int unsigned CTL_BASE = MBX_CTL_BASE,
    parameter int unsigned SET_BASE = MBX_SET_BASE,
    parameter int unsigned CLR_BASE = MBX_CLR_BASE,
    localparam int unsigned NBOX    = NCORE * MPC,
    localparam int unsigned IW      = $clog2(NBOX),
    localparam int unsigned CW      = $clog2(NCORE)
) (
    input  logic [AW-1:0] addr,
    output mbx_op_e       op,
    output logic [IW-1:0] idx
);
    localparam logic [AW:0] SET_LO = (AW+1)'(SET_BASE);
    localparam logic [AW:0] SET_HI = (AW+1)'(SET_BASE + NBOX*4);
    localparam logic [AW:0] CLR_LO = (AW+1)'(CLR_BASE);
    localparam logic [AW:0] CLR_HI = (AW+1)'(CLR_BASE + NBOX*4);
    localparam logic [AW:0] CTL_LO = (AW+1)'(CTL_BASE);
    localparam logic [AW:0] CTL_HI = (AW+1)'(CTL_BASE + NCORE*4);

    logic [AW:0]   a_ext;
    logic [IW+1:0] set_off;
    logic [IW+1:0] clr_off;
    logic [CW+1:0] ctl_off;

    assign a_ext   = {1'b0, addr};
    assign set_off = (IW+2)'(a_ext - SET_LO);
    assign clr_off = (IW+2)'(a_ext - CLR_LO);
    assign ctl_off = (CW+2)'(a_ext - CTL_LO);

    always_comb begin
        op  = OP_NONE;
        idx = '0;
        if (a_ext >= SET_LO && a_ext < SET_HI && set_off[1:0] == 2'b00) begin
            op  = OP_SET;
            idx = set_off[IW+1:2];
        end else if (a_ext >= CLR_LO && a_ext < CLR_HI && clr_off[1:0] == 2'b00) begin
            op  = OP_CLR;
            idx = clr_off[IW+1:2];
        end else if (a_ext >= CTL_LO && a_ext < CTL_HI && ctl_off[1:0] == 2'b00) begin
            op  = OP_CTL;
            idx = IW'(ctl_off[CW+1:2]);
        end
    end
endmodule

// File: rtl/mbox_irq_route.sv
module mbox_irq_route #(
    parameter int unsigned MPC = 4
) (
    input  logic [MPC-1:0]   busy,
    input  logic [2*MPC-1:0] route,
    output logic [MPC-1:0]   irq,
    output logic [MPC-1:0]   fiq
);
    logic [MPC-1:0] en_norm;
    logic [MPC-1:0] en_fast;

    assign en_norm = route[MPC-1:0];
    assign en_fast = route[2*MPC-1:MPC];

    always_comb begin
        fiq = busy & en_fast;
        irq = busy & en_norm & ~en_fast;
    end
endmodule

// File: rtl/mbox_doorbell_unit.sv
module mbox_doorbell_unit
    import mbox_pkg::*;
#(
    parameter int unsigned NPORT    = MBX_PORTS,
    parameter int unsigned NCORE    = MBX_CORES,
    parameter int unsigned MPC      = MBX_PER_CORE,
    parameter int unsigned DW       = MBX_DW,
    parameter int unsigned AW       = MBX_AW,
    parameter int unsigned CTL_BASE = MBX_CTL_BASE,
    parameter int unsigned SET_BASE = MBX_SET_BASE,
    parameter int unsigned CLR_BASE = MBX_CLR_BASE
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPORT-1:0]       bus_valid,
    input  logic [NPORT-1:0]       bus_write,
    input  logic [NPORT*AW-1:0]    bus_addr,
    input  logic [NPORT*DW-1:0]    bus_wdata,
    output logic [NPORT*DW-1:0]    bus_rdata,
    output logic [NCORE*MPC-1:0]   mbx_irq,
    output logic [NCORE*MPC-1:0]   mbx_fiq
);
    localparam int unsigned NBOX = NCORE * MPC;
    localparam int unsigned IW   = $clog2(NBOX);
    localparam int unsigned CW   = $clog2(NCORE);
    localparam int unsigned RW   = 2 * MPC;

    typedef struct packed {
        logic [NBOX-1:0][DW-1:0]  box;
        logic [NCORE-1:0][RW-1:0] route;
        logic [NBOX-1:0]          irq;
        logic [NBOX-1:0]          fiq;
        logic [NPORT-1:0][DW-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    mbx_op_e         dec_op  [NPORT];
    logic [IW-1:0]   dec_idx [NPORT];
    logic [NPORT-1:0] wr_en;
    logic [NPORT-1:0] rd_en;
    logic [NBOX-1:0] busy;
    logic [NBOX-1:0] irq_nx;
    logic [NBOX-1:0] fiq_nx;

    assign wr_en = bus_valid & bus_write;
    assign rd_en = bus_valid & ~bus_write;

    // one address decoder per bus port
    for (genvar gp = 0; gp < NPORT; gp++) begin : g_dec
        mbox_addr_decode #(
            .AW(AW), .NCORE(NCORE), .MPC(MPC),
            .CTL_BASE(CTL_BASE), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
        ) u_dec (
            .addr (bus_addr[gp*AW +: AW]),
            .op   (dec_op[gp]),
            .idx  (dec_idx[gp])
        );
    end

    // request routing per core, from the registered state
    for (genvar gc = 0; gc < NCORE; gc++) begin : g_route
        for (genvar gm = 0; gm < MPC; gm++) begin : g_busy
            assign busy[gc*MPC + gm] = |st_q.box[gc*MPC + gm];
        end
        mbox_irq_route #(.MPC(MPC)) u_route (
            .busy  (busy[gc*MPC +: MPC]),
            .route (st_q.route[gc]),
            .irq   (irq_nx[gc*MPC +: MPC]),
            .fiq   (fiq_nx[gc*MPC +: MPC])
        );
    end

    always_comb begin
        st_d = st_q;
        // sets from every port first
        for (int p = 0; p < NPORT; p++) begin
            if (wr_en[p] && dec_op[p] == OP_SET) begin
                st_d.box[dec_idx[p]] = st_d.box[dec_idx[p]] | bus_wdata[p*DW +: DW];
            end
        end
        // then clears, so a colliding clear wins
        for (int p = 0; p < NPORT; p++) begin
            if (wr_en[p] && dec_op[p] == OP_CLR) begin
                st_d.box[dec_idx[p]] = st_d.box[dec_idx[p]] & ~bus_wdata[p*DW +: DW];
            end
        end
        // routing writes, highest port last
        for (int p = 0; p < NPORT; p++) begin
            if (wr_en[p] && dec_op[p] == OP_CTL) begin
                st_d.route[dec_idx[p][CW-1:0]] = bus_wdata[p*DW +: RW];
            end
        end
        // reads see the state before this cycle's writes
        for (int p = 0; p < NPORT; p++) begin
            if (rd_en[p]) begin
                case (dec_op[p])
                    OP_CLR:  st_d.rdata[p] = st_q.box[dec_idx[p]];
                    OP_CTL:  st_d.rdata[p] = DW'(st_q.route[dec_idx[p][CW-1:0]]);
                    default: st_d.rdata[p] = '0;
                endcase
            end
        end
        st_d.irq = irq_nx;
        st_d.fiq = fiq_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign mbx_irq   = st_q.irq;
    assign mbx_fiq   = st_q.fiq;

    // ---------------- assertions ----------------
    logic [NBOX-1:0]         box_hit;
    logic [NBOX-1:0][DW-1:0] clr_mask;

    always_comb begin
        box_hit  = '0;
        clr_mask = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (wr_en[p] && (dec_op[p] == OP_SET || dec_op[p] == OP_CLR)) begin
                box_hit[dec_idx[p]] = 1'b1;
            end
            if (wr_en[p] && dec_op[p] == OP_CLR) begin
                clr_mask[dec_idx[p]] = clr_mask[dec_idx[p]] | bus_wdata[p*DW +: DW];
            end
        end
    end

    assert_irq_fiq_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(mbx_irq & mbx_fiq)));

    for (genvar gi = 0; gi < NBOX; gi++) begin : g_chk
        assert_box_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !box_hit[gi] |=> $stable(st_q.box[gi]));

        assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (box_hit[gi] && (|clr_mask[gi])) |=> ((st_q.box[gi] & $past(clr_mask[gi])) == '0));

        assert_fiq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
            mbx_fiq[gi] |-> $past((|st_q.box[gi]) && st_q.route[gi/MPC][MPC + gi%MPC]));

        assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
            mbx_irq[gi] |-> $past((|st_q.box[gi]) && st_q.route[gi/MPC][gi%MPC]
                                  && !st_q.route[gi/MPC][MPC + gi%MPC]));
    end

    for (genvar gp = 0; gp < NPORT; gp++) begin : g_rchk
        assert_set_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en[gp] && dec_op[gp] == OP_SET) |=> (bus_rdata[gp*DW +: DW] == '0));
    end
endmodule

// File: tb/tb_mbox_doorbell_unit.sv
module tb_mbox_doorbell_unit;
    localparam int NP = 2;
    localparam int AW = 8;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     bus_valid = '0;
    logic [NP-1:0]     bus_write = '0;
    logic [NP*AW-1:0]  bus_addr  = '0;
    logic [NP*DW-1:0]  bus_wdata = '0;
    logic [NP*DW-1:0]  bus_rdata;
    logic [15:0]       mbx_irq;
    logic [15:0]       mbx_fiq;

    int vectors = 0;
    int miscompares = 0;

    logic [31:0] mb [16];
    logic [7:0]  mr [4];

    mbox_doorbell_unit dut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mbx_irq(mbx_irq), .mbx_fiq(mbx_fiq)
    );

    always #10 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // apply one write to the bench model, from the address rules
    task automatic model_wr(logic [7:0] a, logic [31:0] d, bit do_set, bit do_clr, bit do_ctl);
        if (a[1:0] == 2'b00) begin
            if (do_set && a >= 8'h80 && a < 8'hC0) mb[(a - 8'h80) >> 2] |= d;
            if (do_clr && a >= 8'hC0)              mb[(a - 8'hC0) >> 2] &= ~d;
            if (do_ctl && a >= 8'h50 && a < 8'h60) mr[(a - 8'h50) >> 2] = d[7:0];
        end
    endtask

    task automatic check_lines(string req);
        logic [15:0] ei, ef;
        for (int i = 0; i < 16; i++) begin
            logic busy, fen, nen;
            busy = |mb[i];
            fen  = mr[i/4][4 + i%4];
            nen  = mr[i/4][i%4];
            ef[i] = busy & fen;
            ei[i] = busy & nen & ~fen;
        end
        check({req, " irq"}, {16'h0, mbx_irq}, {16'h0, ei});
        check({req, " fiq"}, {16'h0, mbx_fiq}, {16'h0, ef});
    endtask

    task automatic idle();
        bus_valid = '0;
        bus_write = '0;
    endtask

    task automatic wr(int p, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid[p] = 1'b1;
        bus_write[p] = 1'b1;
        bus_addr[p*AW +: AW]  = a;
        bus_wdata[p*DW +: DW] = d;
        @(negedge clk);
        idle();
        model_wr(a, d, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic rd(int p, logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid[p] = 1'b1;
        bus_write[p] = 1'b0;
        bus_addr[p*AW +: AW] = a;
        @(negedge clk);
        d = bus_rdata[p*DW +: DW];
        idle();
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 rdata", bus_rdata[31:0], 32'h0);
        check_lines("R1");
        rd(0, 8'hC0, v);  check("R1 box0", v, 32'h0);
        rd(1, 8'hFC, v);  check("R1 box15", v, 32'h0);
        rd(0, 8'h5C, v);  check("R1 route3", v, 32'h0);
    endtask

    task automatic t_set_or();
        logic [31:0] v;
        wr(0, 8'h54, 32'h0000_000F);          // core1 normal enables
        wr(0, 8'h98, 32'h0000_0005);          // core1 doorbell2 set
        wr(1, 8'h98, 32'h0000_0030);
        settle();
        rd(0, 8'hD8, v);  check("R2 or-merge", v, 32'h35);
        rd(1, 8'h98, v);  check("R4 set-addr reads zero", v, 32'h0);
        check_lines("R6 normal line");
    endtask

    task automatic t_clear_level();
        logic [31:0] v;
        wr(0, 8'hD8, 32'h0000_0001);
        settle();
        rd(0, 8'hD8, v);  check("R3 partial clear", v, 32'h34);
        check_lines("R8 level held");
        wr(1, 8'hD8, 32'hFFFF_FF34 & 32'h34);
        settle();
        check("R8 line falls", {31'h0, mbx_irq[6]}, 32'h0);
        check_lines("R3 all cleared");
    endtask

    task automatic t_fast_override();
        logic [31:0] v;
        wr(0, 8'h58, 32'h0000_0011);          // core2 both enables, doorbell0
        wr(0, 8'hA0, 32'h0000_0001);
        settle();
        check("R7 fast wins", {30'h0, mbx_fiq[8], mbx_irq[8]}, 32'h2);
        check_lines("R7");
        wr(1, 8'h58, 32'h0000_0001);
        settle();
        check("R6 normal only", {30'h0, mbx_fiq[8], mbx_irq[8]}, 32'h1);
        wr(1, 8'h58, 32'h0000_0000);
        settle();
        check_lines("R6 disabled");
        rd(0, 8'hE0, v);  check("R8 word kept", v, 32'h1);
    endtask

    task automatic t_latency();
        wr(0, 8'h5C, 32'h0000_0010);          // core3 fast enable doorbell0
        @(negedge clk);
        bus_valid[0] = 1'b1; bus_write[0] = 1'b1;
        bus_addr[0 +: AW] = 8'hB0; bus_wdata[0 +: DW] = 32'h8000_0000;
        @(negedge clk);                        // edge k passed
        idle();
        model_wr(8'hB0, 32'h8000_0000, 1'b1, 1'b0, 1'b0);
        check("R10 before edge k+1", {31'h0, mbx_fiq[12]}, 32'h0);
        @(negedge clk);                        // edge k+1 passed
        check("R10 at edge k+1", {31'h0, mbx_fiq[12]}, 32'h1);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        @(negedge clk);
        bus_valid = 2'b11; bus_write = 2'b11;
        bus_addr  = {8'hC4, 8'h84};            // port1 clear, port0 set, core0 doorbell1
        bus_wdata = {32'h0000_000F, 32'h0000_00FF};
        @(negedge clk);
        idle();
        model_wr(8'h84, 32'hFF, 1'b1, 1'b0, 1'b0);
        model_wr(8'hC4, 32'h0F, 1'b0, 1'b1, 1'b0);
        rd(0, 8'hC4, v);  check("R9 clear after set", v, 32'hF0);
    endtask

    task automatic t_route_regs();
        logic [31:0] v;
        @(negedge clk);
        bus_valid = 2'b11; bus_write = 2'b11;
        bus_addr  = {8'h50, 8'h50};
        bus_wdata = {32'h0000_0022, 32'h0000_0011};
        @(negedge clk);
        idle();
        mr[0] = 8'h22;
        rd(1, 8'h50, v);  check("R12 high port wins", v, 32'h22);
        wr(0, 8'h50, 32'hFFFF_FFFF);
        rd(0, 8'h50, v);  check("R5 8-bit route", v, 32'hFF);
        settle();
        check_lines("R5 route effect");
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        logic [15:0] irq_before, fiq_before;
        settle();
        irq_before = mbx_irq;
        fiq_before = mbx_fiq;
        wr(0, 8'h82, 32'hFFFF_FFFF);          // unaligned set
        wr(1, 8'hC5, 32'hFFFF_FFFF);          // unaligned clear
        wr(0, 8'h40, 32'hFFFF_FFFF);          // unmapped
        wr(1, 8'h60, 32'hFFFF_FFFF);          // just past routing window
        wr(0, 8'h51, 32'h0000_0000);          // unaligned routing
        settle();
        check("R11 irq unchanged", {16'h0, mbx_irq}, {16'h0, irq_before});
        check("R11 fiq unchanged", {16'h0, mbx_fiq}, {16'h0, fiq_before});
        for (int i = 0; i < 16; i++) begin
            rd(i % 2, 8'(8'hC0 + 4*i), v);
            check("R11 doorbell", v, mb[i]);
        end
        for (int c = 0; c < 4; c++) begin
            rd(0, 8'(8'h50 + 4*c), v);
            check("R11 route", v, {24'h0, mr[c]});
        end
    endtask

    initial begin
        #(20 * 200000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mb[i] = '0;
        for (int c = 0; c < 4; c++) mr[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_or();
        t_clear_level();
        t_fast_override();
        t_latency();
        t_collision();
        t_route_regs();
        t_ignored();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule